// File: doc/BRIEF.md
# Scratchpad and Nonvolatile Store Command Controller

This block owns a small volatile scratchpad and the nonvolatile array behind it. It also owns a command register whose bits start bulk transfers between the two, force recalculations in an external lookup engine, and put the chip into a software-requested reset state. Software reaches the scratchpad, the command register and one spare user byte through a simple single-cycle register bus. The nonvolatile array is a behavioural model held inside the block.

The command bits do not all clear the same way. A copy runs in two phases. In the programming phase the block holds still. In the following acknowledge window software must write the copy bit back to 0, and that write commits the scratchpad into the array. If the window ends first, the copy is aborted and an error flag is raised. A recall loads the array into the scratchpad and clears its own bit. The two recalculation bits stay at 1 until the engine reports completion. The reset-state bit clears only on a serial bus START or STOP event, which another block reports. The programming voltage is sampled when a copy starts. Without it, the copy runs through both phases but writes nothing.

Top module: `scp_eeprom_ctrl`

## Requirements
- R1: After reset, the command register reads 00h, the user byte reads 00h, every scratchpad byte and every array byte is 00h, and `calc_start_o` and `rst_state_o` are low.
- R2: The command register is at address 7Eh. Writing it with bit 0 (copy) = 1 while idle starts a copy. Bit 0 reads 1 through a programming phase of COPY_CYCLES cycles and then through an acknowledge window of WIN_CYCLES cycles, during which bit 6 reads 1. A command write with bit 0 = 0 inside the window clears bit 0 and stores all scratchpad bytes in the array.
- R3: The programming voltage input is sampled in the cycle the copy starts. If it is low then, the array stays unchanged, even if the input rises later in the copy.
- R4: If the window ends without a clearing write, hardware clears bit 0, sets bit 5 (copy error) and leaves the array unchanged. Bit 5 returns to 0 when the next copy starts.
- R5: Writing bit 1 (recall) = 1 while idle loads the array into the scratchpad after RECALL_CYCLES cycles. Bit 1 reads 1 until then and clears by itself.
- R6: While a copy (either phase) or a recall is in progress, these writes have no effect: writes to the scratchpad, and command writes other than the clearing write in the window. If copy and recall are requested in the same write, only the copy runs.
- R7: Writing bit 2 = 1 requests a stored-voltage recalculation. `calc_start_o` pulses for exactly one cycle with `calc_src_o` = 0. Bit 2 stays 1, and writing it with 0 does not clear it, until `calc_done_i` arrives, which clears it.
- R8: Writing bit 3 = 1 requests a live-voltage recalculation with `calc_src_o` = 1, cleared the same way. When both are pending, the stored-voltage request is issued first and the live one only after the first completion.
- R9: Writing bit 4 = 1 sets `rst_state_o` and bit 4. Both stay set until a `bus_evt_i` pulse clears them.
- R10: Address 7Fh is a user byte that can be written and read freely. Writing it changes no command bit, starts nothing and does not touch the array.
- R11: Scratchpad byte i is at address i, for i below SP_DEPTH. Reads of any other unmapped address return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| vprog_i | input | 1 | Programming voltage present |
| bus_evt_i | input | 1 | Serial bus START or STOP seen (one-cycle pulse) |
| calc_done_i | input | 1 | Recalculation finished (one-cycle pulse) |
| calc_start_o | output | 1 | Recalculation start pulse |
| calc_src_o | output | 1 | Voltage source: 0 stored, 1 live |
| rst_state_o | output | 1 | Software reset state active |

## Verification
The copy path is tried with four patterns, and a later recall makes the array contents visible in each case. In the first, the voltage is present and the clearing write comes in time. In the second, the voltage is absent at the start and arrives late. In the third, the window is left to expire. In the fourth, a copy starts just after an expired one. These four patterns separate a commit that follows the sampled voltage from one that follows the live voltage, and a commit on the clearing write from a commit on timeout. Writes are issued in the middle of a copy and of a recall, which shows whether the frozen state leaks. The recalculation path is tried with a single request, with a premature write of 0, and with both requests at once, which checks the issue order and that each bit clears only on its own completion.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_WIN    = 2'd2,
    OP_RECALL = 2'd3
  } op_state_e;

  localparam int unsigned B_COPY   = 0;
  localparam int unsigned B_RECALL = 1;
  localparam int unsigned B_STORED = 2;
  localparam int unsigned B_LIVE   = 3;
  localparam int unsigned B_RST    = 4;
  localparam int unsigned B_ERR    = 5;
  localparam int unsigned B_WIN    = 6;
endpackage

// File: rtl/scp_nv_array.sv
module scp_nv_array #(
  parameter int unsigned DEPTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DEPTH*8-1:0] wdata_i,
  output logic [DEPTH*8-1:0] rdata_o
);
  logic [DEPTH*8-1:0] cells_q;

  // behavioural model, factory contents all zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cells_q <= '0;
    else if (we_i) cells_q <= wdata_i;
  end

  assign rdata_o = cells_q;
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_idx_i,
  input  logic [7:0]         wr_data_i,
  input  logic               load_i,
  input  logic [DEPTH*8-1:0] load_data_i,
  output logic [DEPTH*8-1:0] data_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (load_i) byte_q <= load_data_i[g*8 +: 8];
      else if (wr_en_i && (wr_idx_i == AW'(g))) byte_q <= wr_data_i;
    end
    assign data_o[g*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/scp_op_ctrl.sv
module scp_op_ctrl
  import scp_pkg::*;
#(
  parameter int unsigned COPY_CYCLES   = 20,
  parameter int unsigned WIN_CYCLES    = 50,
  parameter int unsigned RECALL_CYCLES = 8,
  localparam int unsigned MAXC = (COPY_CYCLES > WIN_CYCLES)
      ? ((COPY_CYCLES > RECALL_CYCLES) ? COPY_CYCLES : RECALL_CYCLES)
      : ((WIN_CYCLES > RECALL_CYCLES) ? WIN_CYCLES : RECALL_CYCLES),
  localparam int unsigned CW = $clog2(MAXC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_we_i,
  input  logic copy_bit_i,
  input  logic recall_bit_i,
  input  logic vprog_i,
  output logic copy_o,
  output logic recall_o,
  output logic win_o,
  output logic err_o,
  output logic busy_o,
  output logic nv_we_o,
  output logic sp_load_o
);
  op_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic vok_q, err_q;
  logic cnt_zero, ack_wr;

  assign cnt_zero = (cnt_q == '0);
  assign ack_wr   = cmd_we_i && !copy_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= OP_IDLE;
      cnt_q <= '0;
      vok_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      unique case (st_q)
        OP_IDLE: begin
          if (cmd_we_i && copy_bit_i) begin
            st_q  <= OP_PROG;
            cnt_q <= CW'(COPY_CYCLES - 1);
            vok_q <= vprog_i;
            err_q <= 1'b0;
          end else if (cmd_we_i && recall_bit_i) begin
            st_q  <= OP_RECALL;
            cnt_q <= CW'(RECALL_CYCLES - 1);
          end
        end
        OP_PROG: begin
          if (cnt_zero) begin
            st_q  <= OP_WIN;
            cnt_q <= CW'(WIN_CYCLES - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        OP_WIN: begin
          if (ack_wr) st_q <= OP_IDLE;
          else if (cnt_zero) begin
            st_q  <= OP_IDLE;
            err_q <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        OP_RECALL: begin
          if (cnt_zero) st_q <= OP_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= OP_IDLE;
      endcase
    end
  end

  assign copy_o    = (st_q == OP_PROG) || (st_q == OP_WIN);
  assign recall_o  = (st_q == OP_RECALL);
  assign win_o     = (st_q == OP_WIN);
  assign err_o     = err_q;
  assign busy_o    = (st_q != OP_IDLE);
  assign nv_we_o   = (st_q == OP_WIN) && ack_wr && vok_q;
  assign sp_load_o = (st_q == OP_RECALL) && cnt_zero;

  p_commit_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_we_o |=> !copy_o);
  p_err_on_expiry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(win_o));
  p_recall_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_load_o |=> !recall_o);
  p_single_op_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({copy_o, recall_o}));
  p_commit_needs_vprog_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_o && !vok_q) |-> !nv_we_o);
endmodule

// File: rtl/scp_calc_ctrl.sv
module scp_calc_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_stored_i,
  input  logic set_live_i,
  input  logic done_i,
  output logic stored_o,
  output logic live_o,
  output logic start_o,
  output logic src_o
);
  logic stored_q, live_q, busy_q, start_q, src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stored_q <= 1'b0;
      live_q   <= 1'b0;
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      src_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (set_stored_i) stored_q <= 1'b1;
      if (set_live_i)   live_q   <= 1'b1;
      if (busy_q && done_i) begin
        busy_q <= 1'b0;
        if (src_q) live_q <= 1'b0;
        else stored_q <= 1'b0;
      end else if (!busy_q && (stored_q || live_q)) begin
        // stored-voltage request has priority
        busy_q  <= 1'b1;
        start_q <= 1'b1;
        src_q   <= !stored_q;
      end
    end
  end

  assign stored_o = stored_q;
  assign live_o   = live_q;
  assign start_o  = start_q;
  assign src_o    = src_q;

  p_start_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  p_src_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> $stable(src_q));
  p_stored_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stored_q && !(busy_q && done_i)) |=> stored_q);
  p_stored_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && stored_q) |-> !src_q);
endmodule

// File: rtl/scp_eeprom_ctrl.sv
module scp_eeprom_ctrl
  import scp_pkg::*;
#(
  parameter int unsigned SP_DEPTH      = 16,
  parameter int unsigned COPY_CYCLES   = 20,
  parameter int unsigned WIN_CYCLES    = 50,
  parameter int unsigned RECALL_CYCLES = 8,
  parameter logic [7:0]  CMD_ADDR      = 8'h7E,
  parameter logic [7:0]  USER_ADDR     = 8'h7F,
  localparam int unsigned SP_AW = (SP_DEPTH > 1) ? $clog2(SP_DEPTH) : 1,
  localparam logic [7:0] SP_LIMIT = 8'(SP_DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_we_i,
  input  logic [7:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       vprog_i,
  input  logic       bus_evt_i,
  input  logic       calc_done_i,
  output logic       calc_start_o,
  output logic       calc_src_o,
  output logic       rst_state_o
);
  logic [SP_DEPTH*8-1:0] sp_flat, nv_flat;
  logic sel_cmd, sel_user, sel_sp;
  logic cmd_we, cmd_ok, sp_we;
  logic copy_b, recall_b, win_b, err_b, busy, nv_we, sp_load;
  logic stored_b, live_b;
  logic rst_q;
  logic [7:0] user_q;
  logic unused_wbits;

  assign sel_cmd  = (bus_addr_i == CMD_ADDR);
  assign sel_user = (bus_addr_i == USER_ADDR);
  assign sel_sp   = (bus_addr_i < SP_LIMIT);
  assign cmd_we   = bus_we_i && sel_cmd;
  assign cmd_ok   = cmd_we && !busy;
  assign sp_we    = bus_we_i && sel_sp && !busy;
  assign unused_wbits = ^bus_wdata_i[7:5];

  scp_op_ctrl #(
    .COPY_CYCLES  (COPY_CYCLES),
    .WIN_CYCLES   (WIN_CYCLES),
    .RECALL_CYCLES(RECALL_CYCLES)
  ) u_op (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we),
    .copy_bit_i  (bus_wdata_i[B_COPY]),
    .recall_bit_i(bus_wdata_i[B_RECALL]),
    .vprog_i     (vprog_i),
    .copy_o      (copy_b),
    .recall_o    (recall_b),
    .win_o       (win_b),
    .err_o       (err_b),
    .busy_o      (busy),
    .nv_we_o     (nv_we),
    .sp_load_o   (sp_load)
  );

  scp_regfile #(.DEPTH(SP_DEPTH)) u_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (sp_we),
    .wr_idx_i   (bus_addr_i[SP_AW-1:0]),
    .wr_data_i  (bus_wdata_i),
    .load_i     (sp_load),
    .load_data_i(nv_flat),
    .data_o     (sp_flat)
  );

  scp_nv_array #(.DEPTH(SP_DEPTH)) u_nv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (nv_we),
    .wdata_i(sp_flat),
    .rdata_o(nv_flat)
  );

  scp_calc_ctrl u_calc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_stored_i(cmd_ok && bus_wdata_i[B_STORED]),
    .set_live_i  (cmd_ok && bus_wdata_i[B_LIVE]),
    .done_i      (calc_done_i),
    .stored_o    (stored_b),
    .live_o      (live_b),
    .start_o     (calc_start_o),
    .src_o       (calc_src_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else if (bus_evt_i) rst_q <= 1'b0;
    else if (cmd_ok && bus_wdata_i[B_RST]) rst_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) user_q <= '0;
    else if (bus_we_i && sel_user) user_q <= bus_wdata_i;
  end

  assign rst_state_o = rst_q;

  always_comb begin
    bus_rdata_o = '0;
    if (sel_cmd) begin
      bus_rdata_o[B_COPY]   = copy_b;
      bus_rdata_o[B_RECALL] = recall_b;
      bus_rdata_o[B_STORED] = stored_b;
      bus_rdata_o[B_LIVE]   = live_b;
      bus_rdata_o[B_RST]    = rst_q;
      bus_rdata_o[B_ERR]    = err_b;
      bus_rdata_o[B_WIN]    = win_b;
    end else if (sel_user) bus_rdata_o = user_q;
    else if (sel_sp) bus_rdata_o = sp_flat[bus_addr_i[SP_AW-1:0]*8 +: 8];
  end

  p_rst_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_evt_i |=> !rst_state_o);
  p_sp_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !sp_load) |=> $stable(sp_flat));
  p_user_inert_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && sel_user) |-> !nv_we);
endmodule

// File: tb/scp_eeprom_ctrl_tb.sv
module scp_eeprom_ctrl_tb;
  localparam int WIN_CYCLES = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic vprog = 1'b0;
  logic evt = 1'b0;
  logic done = 1'b0;
  logic cstart, csrc, rstate;

  int n_chk = 0;
  int n_bad = 0;
  int n_start = 0;
  logic last_src = 1'b0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  scp_eeprom_ctrl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .vprog_i     (vprog),
    .bus_evt_i   (evt),
    .calc_done_i (done),
    .calc_start_o(cstart),
    .calc_src_o  (csrc),
    .rst_state_o (rstate)
  );

  always @(negedge clk) if (cstart) begin
    n_start++;
    last_src = csrc;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdb(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cmd(input int b, input logic v, output bit ok);
    logic [7:0] r;
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      rdb(8'h7E, r);
      if (r[b] == v) begin ok = 1; break; end
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic do_recall();
    bit ok;
    wr(8'h7E, 8'h02);
    wait_cmd(1, 1'b0, ok);
    check("R5 recall bit self clear", {7'd0, ok}, 8'h01);
  endtask

  task automatic t_reset();
    rdb(8'h7E, rd); check("R1 cmd", rd, 8'h00);
    rdb(8'h7F, rd); check("R1 user", rd, 8'h00);
    rdb(8'h05, rd); check("R1 scratchpad", rd, 8'h00);
    check("R1 outputs", {6'd0, cstart, rstate}, 8'h00);
    do_recall();
    rdb(8'h00, rd); check("R1 array zero", rd, 8'h00);
  endtask

  task automatic t_user();
    int s0 = n_start;
    wr(8'h7F, 8'hA5);
    rdb(8'h7F, rd); check("R10 user readback", rd, 8'hA5);
    rdb(8'h7E, rd); check("R10 cmd untouched", rd, 8'h00);
    repeat (3) @(negedge clk);
    check("R10 no calc start", 8'(n_start - s0), 8'h00);
    rdb(8'h40, rd); check("R11 unmapped read", rd, 8'h00);
  endtask

  task automatic t_copy_ok();
    bit ok;
    wr(8'h00, 8'h11); wr(8'h01, 8'h22); wr(8'h0F, 8'h44);
    rdb(8'h0F, rd); check("R11 last sp byte", rd, 8'h44);
    vprog = 1'b1;
    wr(8'h7E, 8'h01);
    rdb(8'h7E, rd); check("R2 copy prog phase", rd, 8'h01);
    wr(8'h00, 8'hFF);
    rdb(8'h00, rd); check("R6 sp write ignored in copy", rd, 8'h11);
    wr(8'h7E, 8'h04);
    rdb(8'h7E, rd); check("R6 calc write ignored in copy", rd, 8'h01);
    wait_cmd(6, 1'b1, ok);
    check("R2 window opens", {7'd0, ok}, 8'h01);
    wr(8'h7E, 8'h00);
    rdb(8'h7E, rd); check("R2 copy cleared", rd, 8'h00);
    wr(8'h00, 8'h00); wr(8'h01, 8'h00);
    wr(8'h7E, 8'h02);
    wr(8'h01, 8'h99);
    rdb(8'h7E, rd); check("R6 cmd during recall", rd, 8'h02);
    wait_cmd(1, 1'b0, ok);
    rdb(8'h00, rd); check("R2 byte0 stored", rd, 8'h11);
    rdb(8'h01, rd); check("R5 byte1 recalled over ignored write", rd, 8'h22);
  endtask

  task automatic t_copy_novprog();
    bit ok;
    wr(8'h00, 8'h55);
    vprog = 1'b0;
    wr(8'h7E, 8'h01);
    vprog = 1'b1;
    wait_cmd(6, 1'b1, ok);
    wr(8'h7E, 8'h00);
    do_recall();
    rdb(8'h00, rd); check("R3 array unchanged without vprog", rd, 8'h11);
  endtask

  task automatic t_copy_expire();
    bit ok;
    wr(8'h00, 8'h77);
    wr(8'h7E, 8'h01);
    wait_cmd(6, 1'b1, ok);
    repeat (WIN_CYCLES + 5) @(negedge clk);
    rdb(8'h7E, rd); check("R4 abort sets error", rd, 8'h20);
    do_recall();
    rdb(8'h00, rd); check("R4 array unchanged on abort", rd, 8'h11);
    wr(8'h7E, 8'h03);
    rdb(8'h7E, rd); check("R4 error cleared, R6 copy wins", rd, 8'h01);
    wait_cmd(6, 1'b1, ok);
    wr(8'h7E, 8'h00);
    rdb(8'h7E, rd); check("R2 second copy done", rd, 8'h00);
  endtask

  task automatic t_calc_stored();
    int s0 = n_start;
    wr(8'h7E, 8'h04);
    repeat (2) @(negedge clk);
    check("R7 one start pulse", 8'(n_start - s0), 8'h01);
    check("R7 src stored", {7'd0, last_src}, 8'h00);
    wr(8'h7E, 8'h00);
    rdb(8'h7E, rd); check("R7 write 0 no clear", rd, 8'h04);
    pulse_done();
    rdb(8'h7E, rd); check("R7 cleared on done", rd, 8'h00);
    check("R7 no extra start", 8'(n_start - s0), 8'h01);
  endtask

  task automatic t_calc_both();
    int s0 = n_start;
    wr(8'h7E, 8'h0C);
    repeat (3) @(negedge clk);
    check("R8 first issue", 8'(n_start - s0), 8'h01);
    check("R8 stored first", {7'd0, last_src}, 8'h00);
    rdb(8'h7E, rd); check("R8 both pending", rd, 8'h0C);
    pulse_done();
    repeat (3) @(negedge clk);
    check("R8 second issue", 8'(n_start - s0), 8'h02);
    check("R8 live src", {7'd0, last_src}, 8'h01);
    rdb(8'h7E, rd); check("R8 live pending", rd, 8'h08);
    pulse_done();
    rdb(8'h7E, rd); check("R8 all clear", rd, 8'h00);
  endtask

  task automatic t_rst_state();
    wr(8'h7E, 8'h10);
    repeat (5) @(negedge clk);
    check("R9 reset state held", {7'd0, rstate}, 8'h01);
    rdb(8'h7E, rd); check("R9 bit4 set", rd, 8'h10);
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
    check("R9 exit on bus event", {7'd0, rstate}, 8'h00);
    rdb(8'h7E, rd); check("R9 bit4 clear", rd, 8'h00);
  endtask

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_user();
    t_copy_ok();
    t_copy_novprog();
    t_copy_expire();
    t_calc_stored();
    t_calc_both();
    t_rst_state();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule